// File: doc/BRIEF.md
# Lock Elision Controller

This per-core controller removes the cost of taking an uncontended lock. It watches the core's memory operation stream. A store-conditional that closes a load-linked/store-conditional pair on the same address is treated as a lock acquire. The controller keeps that store away from memory and puts the core into a speculative mode. Each line the core reads or writes is recorded, speculative stores are held in a small buffer, and speculative loads to a buffered address get the newest buffered value.

Coherence snoops are compared with the recorded line sets. A remote write to any line the section has read is a conflict, and so is any remote access to a line it has written. A set or buffer overflow also counts as a conflict. On a conflict the buffer is dropped, a one-cycle abort pulse tells the core to re-run the section with a real lock, and the controller falls back to passing every store straight to memory until the real release store arrives. When the section ends with a store to the lock address, that store is also withheld, a one-cycle commit pulse is raised, and the buffered stores drain to memory in order. The lock word in memory therefore never changes during a successful elision. A small retry counter stops elision on a lock that keeps aborting.

Top module: `elide_top`

## Requirements
- R1: After reset the block is idle: specActive, busy, commitPulse, abortPulse, memWrEn and fwdHit are all 0.
- R2: A store-conditional (opKind 3) to the address of the most recent load-linked (opKind 2) starts speculation when retries allow. The store is not written to memory, and specActive is 1 from the cycle after.
- R3: Outside speculation and draining, each store (opKind 1) and each store-conditional that does not start an elision or fallback appears on memWrEn/memWrAddr/memWrData one cycle after it is accepted.
- R4: While speculating, a snooped remote write (snpWrite=1) to a line in the read set aborts. The read set includes the lock line. A remote read of a line that has only been read does not abort.
- R5: While speculating, a snooped remote read or remote write to a line in the write set aborts. Lines are address bits [ADDR_W-1:LINE_LSB].
- R6: An abort discards every buffered speculative store, and none of them ever reaches memory.
- R7: A store to the lock address while speculating is the release. It is suppressed, and commitPulse and busy go to 1 one cycle later. The buffered stores are then written one per cycle in program order, starting the cycle after commitPulse. busy drops one cycle after the last of them.
- R8: A speculative load (opKind 0 or 2) whose address is buffered raises fwdHit in the same cycle, with the newest buffered data for that address.
- R9: The read set and the write set each hold 8 lines, and the read set includes the lock line. The buffer holds 8 stores. An access that needs a ninth entry in any of them aborts.
- R10: After an abort, the block stays in fallback with specActive 0 and writes every store to memory, including a store-conditional to the lock address. It returns to idle only on a plain store to the lock address.
- R11: After 2 consecutive aborted elisions on one lock address, further acquires of that address go to fallback and are written. Starting an elision on another address resets the count.
- R12: commitPulse and abortPulse each last exactly one cycle.
- R13: During a successful elision, no write to the lock address reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Core memory operation present |
| opKind | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| opAddr | input | ADDR_W | Operation byte address |
| opData | input | DATA_W | Store data |
| snpValid | input | 1 | Remote snoop present |
| snpWrite | input | 1 | 1 remote write, 0 remote read |
| snpLine | input | ADDR_W-LINE_LSB | Snooped line address |
| fwdHit | output | 1 | Load served from speculative buffer |
| fwdData | output | DATA_W | Forwarded load data |
| specActive | output | 1 | Speculating |
| busy | output | 1 | Draining buffered stores; core must hold operations |
| commitPulse | output | 1 | One-cycle commit indication |
| abortPulse | output | 1 | One-cycle abort, re-execute with real lock |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Memory write address |
| memWrData | output | DATA_W | Memory write data |

## Verification
On every cycle the assertions check several properties. Both pulses last one cycle. An abort always lands in fallback and a commit always lands in draining. Nothing is written to memory while speculating. The line sets and buffer never pass their capacity, the drain pointer never passes the fill pointer, and the retry count never passes its limit. Only the bench scenarios can show which snoops count as conflicts, the exact drain order and data, forwarding of the newest value, the point where each set overflows, and the retry sequence across several acquire and release rounds.

// File: rtl/elide_pkg.sv
package elide_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SPEC     = 2'd1,
    ST_COMMIT   = 2'd2,
    ST_FALLBACK = 2'd3
  } elideState_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_LL    = 2'd2;
  localparam logic [1:0] KIND_SC    = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic rdAdd;
    logic wrAdd;
    logic bufPush;
    logic clearAll;
    logic drainStep;
    logic passWrite;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic rdHitOp;
    logic rdFull;
    logic wrHitOp;
    logic wrFull;
    logic bufFull;
    logic bufEmpty;
    logic snpConflict;
  } dpStat_t;

endpackage

// File: rtl/elide_lineset.sv
module elide_lineset #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              add,
  input  logic [LINE_W-1:0] opLine,
  input  logic [LINE_W-1:0] snpLine,
  output logic              opHit,
  output logic              snpHit,
  output logic              full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  validVec;
  logic [LINE_W-1:0] lineMem [DEPTH];
  logic [CNT_W-1:0]  fillCnt;
  logic [DEPTH-1:0]  opMatch;
  logic [DEPTH-1:0]  snpMatch;
  logic              addOk;

  assign full   = (fillCnt == CNT_W'(DEPTH));
  assign opHit  = |opMatch;
  assign snpHit = |snpMatch;
  assign addOk  = add && !opHit && !full;

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    assign opMatch[i]  = validVec[i] && (lineMem[i] == opLine);
    assign snpMatch[i] = validVec[i] && (lineMem[i] == snpLine);

    always_ff @(posedge clk) begin
      if (!rstN || clr) begin
        validVec[i] <= 1'b0;
        lineMem[i]  <= '0;
      end else if (addOk && fillCnt == CNT_W'(i)) begin
        validVec[i] <= 1'b1;
        lineMem[i]  <= opLine;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) fillCnt <= '0;
    else if (addOk)   fillCnt <= fillCnt + 1'b1;
  end

  AST_SET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(DEPTH)); // R9
  AST_SET_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validVec) == int'(fillCnt)); // R9

endmodule

// File: rtl/elide_wbuf.sv
module elide_wbuf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              lookHit,
  output logic [DATA_W-1:0] lookData,
  input  logic              drainStep,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [CNT_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  rdPtr;

  assign full     = (wrPtr == CNT_W'(DEPTH));
  assign empty    = (rdPtr == wrPtr);
  assign headAddr = addrMem[rdPtr[IDX_W-1:0]];
  assign headData = dataMem[rdPtr[IDX_W-1:0]];

  // later entries override earlier ones: newest match wins
  always_comb begin
    lookHit  = 1'b0;
    lookData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < wrPtr && addrMem[i] == lookAddr) begin
        lookHit  = 1'b1;
        lookData = dataMem[i];
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrMem[i] <= '0;
        dataMem[i] <= '0;
      end else if (push && !full && wrPtr == CNT_W'(i)) begin
        addrMem[i] <= pushAddr;
        dataMem[i] <= pushData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full)      wrPtr <= wrPtr + 1'b1;
      if (drainStep && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= wrPtr); // R7
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full); // R9

endmodule

// File: rtl/elide_dp.sv
module elide_dp
  import elide_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int LINE_LSB  = 4,
  parameter int SET_DEPTH = 8,
  parameter int BUF_DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCmd_t                     cmd,
  input  logic [ADDR_W-1:0]          opAddr,
  input  logic [DATA_W-1:0]          opData,
  input  logic                       snpValid,
  input  logic                       snpWrite,
  input  logic [ADDR_W-LINE_LSB-1:0] snpLine,
  output dpStat_t                    stat,
  output logic                       bufHit,
  output logic [DATA_W-1:0]          bufData,
  output logic                       memWrEn,
  output logic [ADDR_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]          memWrData
);
  localparam int LINE_W = ADDR_W - LINE_LSB;

  logic [LINE_W-1:0] opLine;
  logic              rdSnpHit, wrSnpHit;
  logic [ADDR_W-1:0] headAddr;
  logic [DATA_W-1:0] headData;

  assign opLine = opAddr[ADDR_W-1:LINE_LSB];

  elide_lineset #(.DEPTH(SET_DEPTH), .LINE_W(LINE_W)) uReadSet (
    .clk(clk), .rstN(rstN), .clr(cmd.clearAll), .add(cmd.rdAdd),
    .opLine(opLine), .snpLine(snpLine),
    .opHit(stat.rdHitOp), .snpHit(rdSnpHit), .full(stat.rdFull));

  elide_lineset #(.DEPTH(SET_DEPTH), .LINE_W(LINE_W)) uWriteSet (
    .clk(clk), .rstN(rstN), .clr(cmd.clearAll), .add(cmd.wrAdd),
    .opLine(opLine), .snpLine(snpLine),
    .opHit(stat.wrHitOp), .snpHit(wrSnpHit), .full(stat.wrFull));

  elide_wbuf #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uBuf (
    .clk(clk), .rstN(rstN), .clr(cmd.clearAll), .push(cmd.bufPush),
    .pushAddr(opAddr), .pushData(opData), .lookAddr(opAddr),
    .lookHit(bufHit), .lookData(bufData), .drainStep(cmd.drainStep),
    .headAddr(headAddr), .headData(headData),
    .full(stat.bufFull), .empty(stat.bufEmpty));

  // remote write hits either set; remote read hits only the write set
  assign stat.snpConflict = snpValid &&
                            ((snpWrite && (rdSnpHit || wrSnpHit)) ||
                             (!snpWrite && wrSnpHit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else if (cmd.drainStep) begin
      memWrEn   <= 1'b1;
      memWrAddr <= headAddr;
      memWrData <= headData;
    end else if (cmd.passWrite) begin
      memWrEn   <= 1'b1;
      memWrAddr <= opAddr;
      memWrData <= opData;
    end else begin
      memWrEn   <= 1'b0;
    end
  end

  AST_CLEAR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |-> !(cmd.bufPush || cmd.rdAdd || cmd.wrAdd)); // R6

endmodule

// File: rtl/elide_ctrl.sv
module elide_ctrl
  import elide_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RETRY_MAX = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output elideState_e       state,
  output logic              commitPulse,
  output logic              abortPulse
);
  localparam int RETRY_W = $clog2(RETRY_MAX + 1);

  elideState_e       nState;
  logic              llValid;
  logic [ADDR_W-1:0] llAddr;
  logic [ADDR_W-1:0] lockAddr;
  logic [ADDR_W-1:0] retryAddr;
  logic [RETRY_W-1:0] retryCnt;
  logic isLoad, isStore;
  logic doAbort, doCommit, startSpec, startFb, llSet, llClr;

  assign isLoad  = !opKind[0];
  assign isStore =  opKind[0];

  always_comb begin
    cmd       = '0;
    nState    = state;
    doAbort   = 1'b0;
    doCommit  = 1'b0;
    startSpec = 1'b0;
    startFb   = 1'b0;
    llSet     = 1'b0;
    llClr     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (opValid) begin
          if (opKind == KIND_LL) begin
            llSet = 1'b1;
          end else if (opKind == KIND_SC) begin
            llClr = 1'b1;
            if (llValid && opAddr == llAddr) begin
              if (retryAddr == opAddr && retryCnt >= RETRY_W'(RETRY_MAX)) begin
                startFb        = 1'b1;
                cmd.passWrite  = 1'b1;
                nState         = ST_FALLBACK;
              end else begin
                startSpec = 1'b1;
                cmd.rdAdd = 1'b1;        // lock line joins the read set
                nState    = ST_SPEC;
              end
            end else begin
              cmd.passWrite = 1'b1;
            end
          end else if (opKind == KIND_STORE) begin
            cmd.passWrite = 1'b1;
          end
        end
      end
      ST_SPEC: begin
        if (stat.snpConflict) begin
          doAbort = 1'b1;
        end else if (opValid) begin
          if (isLoad) begin
            if (!stat.rdHitOp && stat.rdFull) doAbort   = 1'b1;
            else                              cmd.rdAdd = 1'b1;
          end else if (opAddr == lockAddr) begin
            doCommit = 1'b1;
            nState   = ST_COMMIT;
          end else if ((!stat.wrHitOp && stat.wrFull) || stat.bufFull) begin
            doAbort = 1'b1;
          end else begin
            cmd.wrAdd   = 1'b1;
            cmd.bufPush = 1'b1;
          end
        end
        if (doAbort) begin
          cmd.clearAll = 1'b1;
          nState       = ST_FALLBACK;
        end
      end
      ST_COMMIT: begin
        if (!stat.bufEmpty) begin
          cmd.drainStep = 1'b1;
        end else begin
          cmd.clearAll = 1'b1;
          nState       = ST_IDLE;
        end
      end
      ST_FALLBACK: begin
        if (opValid && isStore) begin
          cmd.passWrite = 1'b1;
          if (opKind == KIND_STORE && opAddr == lockAddr) nState = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      commitPulse <= 1'b0;
      abortPulse  <= 1'b0;
      llValid     <= 1'b0;
      llAddr      <= '0;
      lockAddr    <= '0;
      retryAddr   <= '0;
      retryCnt    <= '0;
    end else begin
      state       <= nState;
      commitPulse <= doCommit;
      abortPulse  <= doAbort;
      if (llSet) begin
        llValid <= 1'b1;
        llAddr  <= opAddr;
      end else if (llClr) begin
        llValid <= 1'b0;
      end
      if (startSpec || startFb) lockAddr <= opAddr;
      if (startSpec && retryAddr != opAddr) begin
        retryAddr <= opAddr;
        retryCnt  <= '0;
      end else if (doAbort) begin
        retryCnt  <= retryCnt + 1'b1;
      end else if (doCommit) begin
        retryCnt  <= '0;
      end
    end
  end

  AST_COMMIT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse); // R12
  AST_ABORT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse); // R12
  AST_ABORT_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> state == ST_FALLBACK); // R10
  AST_COMMIT_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> state == ST_COMMIT); // R7
  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_W'(RETRY_MAX)); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(commitPulse && abortPulse)); // R12

endmodule

// File: rtl/elide_top.sv
module elide_top
  import elide_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int LINE_LSB  = 4,
  parameter int SET_DEPTH = 8,
  parameter int BUF_DEPTH = 8,
  parameter int RETRY_MAX = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opValid,
  input  logic [1:0]                 opKind,
  input  logic [ADDR_W-1:0]          opAddr,
  input  logic [DATA_W-1:0]          opData,
  input  logic                       snpValid,
  input  logic                       snpWrite,
  input  logic [ADDR_W-LINE_LSB-1:0] snpLine,
  output logic                       fwdHit,
  output logic [DATA_W-1:0]          fwdData,
  output logic                       specActive,
  output logic                       busy,
  output logic                       commitPulse,
  output logic                       abortPulse,
  output logic                       memWrEn,
  output logic [ADDR_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]          memWrData
);
  dpCmd_t      cmd;
  dpStat_t     stat;
  elideState_e state;
  logic        bufHit;

  elide_ctrl #(.ADDR_W(ADDR_W), .RETRY_MAX(RETRY_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opAddr(opAddr), .stat(stat), .cmd(cmd), .state(state),
    .commitPulse(commitPulse), .abortPulse(abortPulse));

  elide_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_LSB(LINE_LSB),
             .SET_DEPTH(SET_DEPTH), .BUF_DEPTH(BUF_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .opAddr(opAddr), .opData(opData),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpLine(snpLine),
    .stat(stat), .bufHit(bufHit), .bufData(fwdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData));

  assign specActive = (state == ST_SPEC);
  assign busy       = (state == ST_COMMIT);
  assign fwdHit     = opValid && !opKind[0] && specActive && bufHit;

  AST_SPEC_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    specActive |=> !memWrEn); // R13
  AST_FWD_ONLY_SPEC: assert property (@(posedge clk) disable iff (!rstN)
    fwdHit |-> specActive); // R8

endmodule

// File: tb/tb_elide_top.sv
module tb_elide_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LB = 4;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_LL = 2'd2, K_SC = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [AW-1:0] opAddr = '0;
  logic [DW-1:0] opData = '0;
  logic snpValid = 1'b0, snpWrite = 1'b0;
  logic [AW-LB-1:0] snpLine = '0;
  logic fwdHit, specActive, busy, commitPulse, abortPulse, memWrEn;
  logic [DW-1:0] fwdData, memWrData;
  logic [AW-1:0] memWrAddr;

  int checks = 0;
  int errors = 0;
  int logCnt = 0;
  logic [AW-1:0] logA [1024];

  elide_top dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opAddr(opAddr), .opData(opData), .snpValid(snpValid),
    .snpWrite(snpWrite), .snpLine(snpLine), .fwdHit(fwdHit),
    .fwdData(fwdData), .specActive(specActive), .busy(busy),
    .commitPulse(commitPulse), .abortPulse(abortPulse),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (logCnt < 1024) logA[logCnt] <= memWrAddr;
      logCnt <= logCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    opValid = 1'b1; opKind = k; opAddr = a; opData = d;
    @(posedge clk); #1;
    opValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); @(posedge clk); #1;
  endtask

  task automatic snoop(input logic w, input logic [AW-1:0] a);
    @(negedge clk);
    snpValid = 1'b1; snpWrite = w; snpLine = a[AW-1:LB];
    @(posedge clk); #1;
    snpValid = 1'b0;
  endtask

  task automatic fwdLoad(input logic [AW-1:0] a, output logic h, output logic [DW-1:0] d);
    @(negedge clk);
    opValid = 1'b1; opKind = K_LD; opAddr = a; opData = '0;
    #5; h = fwdHit; d = fwdData;
    @(posedge clk); #1;
    opValid = 1'b0;
  endtask

  task automatic startElide(input logic [AW-1:0] lk);
    doOp(K_LL, lk, 0);
    doOp(K_SC, lk, 1);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20 && busy; i++) idle();
  endtask

  function automatic int countAddr(input logic [AW-1:0] a, input int from);
    int c = 0;
    for (int i = from; i < logCnt && i < 1024; i++) if (logA[i] == a) c++;
    return c;
  endfunction

  function automatic logic [AW-1:0] lockOf(input int idx);
    return AW'(16'h1000 + idx * 16);
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic h;
    logic [DW-1:0] d;
    int mark;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1 specActive", specActive, 0);
    chk("R1 busy", busy, 0);
    chk("R1 pulses", {commitPulse, abortPulse}, 0);
    chk("R1 memWrEn", memWrEn, 0);
    chk("R1 fwdHit", fwdHit, 0);

    // R3 passthrough stores in idle
    doOp(K_ST, 16'h3000, 32'hAB);
    chk("R3 store en", memWrEn, 1);
    chk("R3 store addr", memWrAddr, 16'h3000);
    chk("R3 store data", memWrData, 32'hAB);
    doOp(K_SC, 16'h3010, 32'hCD);
    chk("R3 unpaired sc", {memWrEn, memWrAddr, memWrData}, {1'b1, 16'h3010, 32'hCD});

    // R2/R7/R13 commit sweep over buffer fill 0..8
    for (int n = 0; n <= 8; n++) begin
      mark = logCnt;
      startElide(lockOf(n));
      chk("R2 spec entered", specActive, 1);
      chk("R2 acquire silent", memWrEn, 0);
      for (int i = 0; i < n; i++) doOp(K_ST, AW'(16'h2000 + i * 16), DW'(n * 256 + i));
      chk("R9 eight fit", abortPulse, 0);
      doOp(K_ST, lockOf(n), 0);
      chk("R7 commit pulse", commitPulse, 1);
      chk("R7 busy", busy, 1);
      chk("R7 release silent", memWrEn, 0);
      for (int i = 0; i < n; i++) begin
        idle();
        chk("R12 commit one cycle", commitPulse, 0);
        chk("R7 drain", {memWrEn, memWrAddr, memWrData},
            {1'b1, AW'(16'h2000 + i * 16), DW'(n * 256 + i)});
      end
      idle();
      chk("R7 drain done", {busy, memWrEn, commitPulse}, 0);
      chk("R13 lock untouched", countAddr(lockOf(n), mark), 0);
    end

    // R8 forwarding newest value, R7 program order
    startElide(lockOf(10));
    doOp(K_ST, 16'h2000, 32'h11);
    doOp(K_ST, 16'h2100, 32'h22);
    doOp(K_ST, 16'h2000, 32'h33);
    fwdLoad(16'h2000, h, d);
    chk("R8 fwd hit", h, 1);
    chk("R8 fwd newest", d, 32'h33);
    fwdLoad(16'h2104, h, d);
    chk("R8 no fwd other addr", h, 0);
    doOp(K_ST, lockOf(10), 0);
    idle(); chk("R7 order 0", {memWrAddr, memWrData}, {16'h2000, 32'h11});
    idle(); chk("R7 order 1", {memWrAddr, memWrData}, {16'h2100, 32'h22});
    idle(); chk("R7 order 2", {memWrAddr, memWrData}, {16'h2000, 32'h33});
    idle();

    // R4/R5/R6/R10 snoop sweep
    for (int w = 0; w < 2; w++) begin
      for (int t = 0; t < 4; t++) begin
        logic [AW-1:0] lk, tgt;
        logic expAbort;
        lk = lockOf(16 + w * 4 + t);
        tgt = (t == 0) ? 16'h4000 : (t == 1) ? 16'h5000 : (t == 2) ? 16'h7F00 : lk;
        expAbort = (t == 1) || ((t == 0 || t == 3) && (w == 1));
        mark = logCnt;
        startElide(lk);
        doOp(K_LD, 16'h4000, 0);
        doOp(K_ST, 16'h5000, 32'h55);
        snoop(w[0], tgt + 16'h4);
        chk((t == 1) ? "R5 write-set snoop" : "R4 read-set snoop", abortPulse, expAbort);
        if (expAbort) begin
          chk("R10 fallback not spec", specActive, 0);
          idle();
          chk("R12 abort one cycle", abortPulse, 0);
          doOp(K_ST, 16'h5800, 32'h9);
          chk("R10 fallback store written", {memWrEn, memWrAddr}, {1'b1, 16'h5800});
          doOp(K_ST, lk, 0);
          chk("R10 release written", {memWrEn, memWrAddr}, {1'b1, lk});
          idle();
          chk("R6 discarded", countAddr(16'h5000, mark), 0);
        end else begin
          chk("R4 no conflict spec", specActive, 1);
          doOp(K_ST, lk, 0);
          idle();
          chk("R7 drain after snoop", {memWrEn, memWrAddr}, {1'b1, 16'h5000});
          idle();
        end
      end
    end

    // R9 read-set capacity sweep (lock line counts)
    for (int k = 1; k <= 8; k++) begin
      startElide(lockOf(32 + k));
      for (int i = 0; i < k; i++) doOp(K_LD, AW'(16'h6000 + i * 16), 0);
      chk("R9 read capacity", abortPulse, (k == 8));
      if (k == 8) doOp(K_ST, lockOf(32 + k), 0);
      else begin doOp(K_ST, lockOf(32 + k), 0); waitIdle(); end
      idle();
    end
    // R9 ninth store to one address overflows buffer
    mark = logCnt;
    startElide(lockOf(42));
    for (int i = 0; i < 9; i++) doOp(K_ST, 16'h6800, DW'(i));
    chk("R9 buffer overflow", abortPulse, 1);
    doOp(K_ST, lockOf(42), 0);
    chk("R6 overflow discarded", countAddr(16'h6800, mark), 0);
    // R9 ninth distinct line overflows write set
    startElide(lockOf(43));
    for (int i = 0; i < 9; i++) doOp(K_ST, AW'(16'h6900 + i * 16), DW'(i));
    chk("R9 write set overflow", abortPulse, 1);
    doOp(K_ST, lockOf(43), 0);

    // R10/R11 retry limit
    for (int r = 0; r < 2; r++) begin
      startElide(lockOf(48));
      chk("R11 elision allowed", specActive, 1);
      snoop(1'b1, lockOf(48));
      chk("R4 lock line write", abortPulse, 1);
      doOp(K_SC, lockOf(48), 1);
      chk("R10 real acquire written", {memWrEn, memWrAddr, specActive}, {1'b1, lockOf(48), 1'b0});
      doOp(K_ST, lockOf(48), 0);
      chk("R10 release written", {memWrEn, memWrAddr}, {1'b1, lockOf(48)});
    end
    startElide(lockOf(48));
    chk("R11 limit reached no spec", specActive, 0);
    chk("R11 acquire written", {memWrEn, memWrAddr}, {1'b1, lockOf(48)});
    doOp(K_ST, lockOf(48), 0);
    startElide(lockOf(49));
    chk("R11 other lock elides", specActive, 1);
    doOp(K_ST, lockOf(49), 0);
    waitIdle(); idle();
    startElide(lockOf(48));
    chk("R11 count reset by other lock", specActive, 1);
    doOp(K_ST, lockOf(48), 0);
    waitIdle(); idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule